// File: doc/BRIEF.md
# Sized Signed/Unsigned Sequential Integer Multiplier

This block is the multiply unit of an integer datapath. Software-visible semantics follow the usual scheme for sized integer multiplication. Each operation selects an operand width of 8, 16 or 32 bits and picks signed or unsigned arithmetic. The unit returns the complete double-width product as a high half and a low half, plus a pair of flags. The flags say whether the high half carries information that the low half alone would lose.

The unit is sequential. A one-cycle start pulse captures both operands, the size and the mode. The operands' magnitudes are then multiplied by a radix-2 shift-and-add loop that consumes one multiplier bit per clock. Only as many bits are processed as the chosen size needs. A final cycle negates the product when exactly one signed operand was negative. The unit then writes the registered results and raises done for one cycle. The results stay put until the next operation completes, so the surrounding pipeline may read them at any later time.

Top module: `mul_seq_unit`

## Requirements
- R1: `size_i` selects the operand width N: 2'b00 gives 8 bits, 2'b01 gives 16 bits, and both 2'b10 and 2'b11 give 32 bits. Only bits N-1..0 of `opa_i` and `opb_i` are used; higher bits have no effect.
- R2: With `signed_i` = 0 the operands are unsigned. The 2N-bit product appears with its low N bits in `prod_lo_o[N-1:0]` and its high N bits in `prod_hi_o[N-1:0]`.
- R3: With `signed_i` = 1 the operands are two's complement numbers of N bits. The 2N-bit two's complement product is split the same way as in R2.
- R4: Bits N and above of `prod_hi_o` and `prod_lo_o` are zero after every completed operation.
- R5: In unsigned mode `cf_o` and `of_o` are both 1 exactly when the high half of the product is nonzero, and both 0 otherwise.
- R6: In signed mode `cf_o` and `of_o` are both 1 exactly when the high half is not N copies of bit N-1 of the low half. This means the product lies outside the signed N-bit range.
- R7: A start pulse that arrives while `busy_o` is high is ignored: the running operation, its result and its completion time are unchanged, and no extra completion follows.
- R8: If start is sampled at clock edge k while idle, `busy_o` is high after edges k through k+N. `done_o` is high only after edge k+N+1, for that single cycle, with `busy_o` low.
- R9: Results and flags change only in the cycle `done_o` rises. They hold their values through idle time and through the next operation until it completes.
- R10: During and after reset, `busy_o`, `done_o`, `cf_o`, `of_o`, `prod_hi_o` and `prod_lo_o` are all zero until an operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; sampled only while idle |
| size_i | input | 2 | Operand width select (R1) |
| signed_i | input | 1 | 1 = signed, 0 = unsigned |
| opa_i | input | 32 | Multiplicand, low N bits used |
| opb_i | input | 32 | Multiplier, low N bits used |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| prod_hi_o | output | 32 | High half of the product, zero above bit N-1 |
| prod_lo_o | output | 32 | Low half of the product, zero above bit N-1 |
| cf_o | output | 1 | Carry flag: high half is significant |
| of_o | output | 1 | Overflow flag: same condition as carry |

## Verification
The bench aims at the edges of the signed range. It covers the most negative value times itself and times one, minus one squared, and minus one times the most negative value. A unit with a missing or misplaced sign correction returns a wrong high half here, or sets the flags on a product that fits. It also feeds garbage in the unused upper operand bits at 8 and 16 bits, and uses the second 32-bit size code. A unit that mis-extends or mis-aligns the multiplier for narrow sizes gives a shifted or corrupted product. Finally, it checks the exact completion cycle, a start pulse in the middle of a run, and result hold across idle time and a following operation. A unit that restarts, completes twice or clears its results early gives the wrong latency, a second done pulse or changed outputs.

// File: rtl/mul_seq_pkg.sv
package mul_seq_pkg;

  // Machine word width; sizes 8 and 16 are fixed sub-widths of it.
  localparam int unsigned XLEN  = 32;
  localparam int unsigned PW    = 2 * XLEN;
  localparam int unsigned CNT_W = $clog2(XLEN);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } op_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIX  = 2'b10
  } mul_state_e;

  // Operand width in bits for a size code.
  function automatic int unsigned op_bits(logic [1:0] s);
    case (s)
      SZ_BYTE: return 8;
      SZ_HALF: return 16;
      default: return XLEN;
    endcase
  endfunction

  // Mask covering the low op_bits(s) bits of a word.
  function automatic logic [XLEN-1:0] half_mask(logic [1:0] s);
    int unsigned n;
    n = op_bits(s);
    if (n >= XLEN) return '1;
    return (XLEN'(1) << n) - XLEN'(1);
  endfunction

  // Zero- or sign-extend the low bits of v to a full word.
  function automatic logic [XLEN-1:0] extend_op(logic [XLEN-1:0] v, logic [1:0] s, logic sgn);
    logic [XLEN-1:0] m;
    m = half_mask(s);
    if (sgn && v[op_bits(s)-1]) return v | ~m;
    return v & m;
  endfunction

  // Absolute value of a word, read as signed when sgn is set.
  function automatic logic [XLEN-1:0] magnitude(logic [XLEN-1:0] x, logic sgn);
    if (sgn && x[XLEN-1]) return ~x + XLEN'(1);
    return x;
  endfunction

  function automatic logic [XLEN-1:0] low_half(logic [PW-1:0] p, logic [1:0] s);
    return p[XLEN-1:0] & half_mask(s);
  endfunction

  function automatic logic [XLEN-1:0] high_half(logic [PW-1:0] p, logic [1:0] s);
    logic [PW-1:0] sh;
    sh = p >> op_bits(s);
    return sh[XLEN-1:0] & half_mask(s);
  endfunction

  // Significance of the high half: nonzero (unsigned) or not a sign copy (signed).
  function automatic logic high_significant(logic [XLEN-1:0] hi, logic [XLEN-1:0] lo,
                                            logic [1:0] s, logic sgn);
    logic [XLEN-1:0] m;
    m = half_mask(s);
    if (!sgn) return hi != '0;
    if (lo[op_bits(s)-1]) return hi != m;
    return hi != '0;
  endfunction

endpackage

// File: rtl/mul_seq_prep.sv
module mul_seq_prep
  import mul_seq_pkg::*;
(
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  input  logic [1:0]      size_i,
  input  logic            signed_i,
  output logic [XLEN-1:0] mcand_o,
  output logic [XLEN-1:0] mplier_o,
  output logic            neg_o
);

  logic [XLEN-1:0] ext_a;
  logic [XLEN-1:0] ext_b;
  logic [XLEN-1:0] mag_b;

  always_comb begin
    ext_a    = extend_op(opa_i, size_i, signed_i);
    ext_b    = extend_op(opb_i, size_i, signed_i);
    mcand_o  = magnitude(ext_a, signed_i);
    mag_b    = magnitude(ext_b, signed_i);
    // Left-align the multiplier so its top bit is always scanned first.
    mplier_o = mag_b << (XLEN - op_bits(size_i));
    neg_o    = signed_i & (ext_a[XLEN-1] ^ ext_b[XLEN-1]);
  end

endmodule

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl
  import mul_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] size_i,
  output logic       busy_o,
  output logic       load_o,
  output logic       step_o,
  output logic       fix_o
);

  mul_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign fix_o  = (state_q == ST_FIX);
  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cnt_q   <= CNT_W'(op_bits(size_i) - 1);
        end
        ST_RUN: if (cnt_q == '0) state_q <= ST_FIX;
                else             cnt_q   <= cnt_q - CNT_W'(1);
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7: a running count only ever steps down, whatever start does
  assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cnt_q != '0) |=> (state_q == ST_RUN && cnt_q == $past(cnt_q) - CNT_W'(1)))
    else $error("start_ignored_chk");

  // R8: the correction cycle is entered only from the last step and lasts one cycle
  assert property (@(posedge clk) disable iff (!rst_n)
    fix_o |=> (state_q == ST_IDLE))
    else $error("fix_single_chk");

endmodule

// File: rtl/mul_seq_core.sv
module mul_seq_core
  import mul_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [XLEN-1:0] mcand_i,
  input  logic [XLEN-1:0] mplier_i,
  input  logic            neg_i,
  output logic [PW-1:0]   prod_o
);

  logic [PW-1:0]   acc_q;
  logic [XLEN-1:0] mcand_q;
  logic [XLEN-1:0] mplier_q;
  logic            neg_q;
  logic [PW-1:0]   addend;

  assign addend = mplier_q[XLEN-1] ? PW'(mcand_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      neg_q    <= 1'b0;
    end else if (load_i) begin
      acc_q    <= '0;
      mcand_q  <= mcand_i;
      mplier_q <= mplier_i;
      neg_q    <= neg_i;
    end else if (step_i) begin
      acc_q    <= {acc_q[PW-2:0], 1'b0} + addend;
      mplier_q <= mplier_q << 1;
    end
  end

  // Sign correction applied on the magnitude product.
  assign prod_o = neg_q ? (~acc_q + PW'(1)) : acc_q;

  // R9: the accumulator moves only on load or step
  assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(acc_q))
    else $error("acc_hold_chk");

endmodule

// File: rtl/mul_seq_fmt.sv
module mul_seq_fmt
  import mul_seq_pkg::*;
(
  input  logic [PW-1:0]   prod_i,
  input  logic [1:0]      size_i,
  input  logic            signed_i,
  output logic [XLEN-1:0] hi_o,
  output logic [XLEN-1:0] lo_o,
  output logic            flag_o
);

  always_comb begin
    hi_o   = high_half(prod_i, size_i);
    lo_o   = low_half(prod_i, size_i);
    flag_o = high_significant(hi_o, lo_o, size_i, signed_i);
  end

endmodule

// File: rtl/mul_seq_unit.sv
module mul_seq_unit
  import mul_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [1:0]  size_i,
  input  logic        signed_i,
  input  logic [31:0] opa_i,
  input  logic [31:0] opb_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [31:0] prod_hi_o,
  output logic [31:0] prod_lo_o,
  output logic        cf_o,
  output logic        of_o
);

  // Named internal events
  logic            load_en;
  logic            step_en;
  logic            fix_en;
  logic [XLEN-1:0] mcand;
  logic [XLEN-1:0] mplier;
  logic            neg;
  logic [PW-1:0]   prod;
  logic [XLEN-1:0] fmt_hi;
  logic [XLEN-1:0] fmt_lo;
  logic            fmt_flag;

  logic [1:0]      size_q;
  logic            sgn_q;
  logic            done_q;
  logic [XLEN-1:0] hi_q;
  logic [XLEN-1:0] lo_q;
  logic            flag_q;

  mul_seq_prep u_prep (
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .size_i   (size_i),
    .signed_i (signed_i),
    .mcand_o  (mcand),
    .mplier_o (mplier),
    .neg_o    (neg)
  );

  mul_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .size_i  (size_i),
    .busy_o  (busy_o),
    .load_o  (load_en),
    .step_o  (step_en),
    .fix_o   (fix_en)
  );

  mul_seq_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_en),
    .step_i   (step_en),
    .mcand_i  (mcand),
    .mplier_i (mplier),
    .neg_i    (neg),
    .prod_o   (prod)
  );

  mul_seq_fmt u_fmt (
    .prod_i   (prod),
    .size_i   (size_q),
    .signed_i (sgn_q),
    .hi_o     (fmt_hi),
    .lo_o     (fmt_lo),
    .flag_o   (fmt_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SZ_WORD;
      sgn_q  <= 1'b0;
      done_q <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      done_q <= fix_en;
      if (load_en) begin
        size_q <= size_i;
        sgn_q  <= signed_i;
      end
      if (fix_en) begin
        hi_q   <= fmt_hi;
        lo_q   <= fmt_lo;
        flag_q <= fmt_flag;
      end
    end
  end

  assign done_o    = done_q;
  assign prod_hi_o = hi_q;
  assign prod_lo_o = lo_q;
  assign cf_o      = flag_q;
  assign of_o      = flag_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && size_q == SZ_BYTE) |-> (prod_hi_o[XLEN-1:8] == '0 && prod_lo_o[XLEN-1:8] == '0));

  // R5
  unsigned_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !sgn_q) |-> (cf_o == (prod_hi_o != '0)));

  // R6
  signed_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && sgn_q && op_bits(size_q) == XLEN) |->
      (of_o == (prod_hi_o != {XLEN{prod_lo_o[XLEN-1]}})));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(prod_hi_o) && $stable(prod_lo_o) && $stable(cf_o)));

endmodule

// File: tb/mul_seq_unit_tb.sv
`timescale 1ns/1ps
module mul_seq_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  size_i = 2'b00;
  logic        signed_i = 1'b0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        busy_o, done_o, cf_o, of_o;
  logic [31:0] prod_hi_o, prod_lo_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mul_seq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
    .signed_i(signed_i), .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o),
    .done_o(done_o), .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o),
    .cf_o(cf_o), .of_o(of_o)
  );

  // Stimulus vectors: {size[1:0], signed, a[31:0], b[31:0]}
  localparam int NVEC = 15;
  localparam logic [66:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 32'h0000_00FF, 32'h0000_00FF},
    {2'b00, 1'b1, 32'h0000_00FF, 32'h0000_00FF},
    {2'b00, 1'b1, 32'h0000_0080, 32'h0000_0080},
    {2'b00, 1'b1, 32'hABCD_FF80, 32'h1234_5601},
    {2'b00, 1'b0, 32'hFFFF_FF10, 32'h5555_550F},
    {2'b01, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF},
    {2'b01, 1'b1, 32'h0000_8000, 32'h0000_FFFF},
    {2'b01, 1'b1, 32'h1234_FFFD, 32'h9876_0007},
    {2'b01, 1'b0, 32'h1234_0010, 32'hABCD_0010},
    {2'b10, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {2'b10, 1'b1, 32'h8000_0000, 32'h8000_0000},
    {2'b10, 1'b1, 32'h8000_0000, 32'h0000_0001},
    {2'b11, 1'b1, 32'hFFFF_FFFE, 32'h0000_0003},
    {2'b10, 1'b0, 32'h0000_0000, 32'h1234_5678},
    {2'b10, 1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural reference from the requirements, via a wide product and range tests.
  task automatic model(input logic [1:0] sz, input logic sgn, input logic [31:0] a,
                       input logic [31:0] b, output logic [31:0] hi,
                       output logic [31:0] lo, output logic fl, output int n);
    longint ea, eb, p, lim;
    logic [63:0] pu, m;
    n = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    m = (64'd1 << n) - 64'd1;
    if (sgn) begin
      case (n)
        8:       begin ea = longint'($signed(a[7:0]));  eb = longint'($signed(b[7:0]));  end
        16:      begin ea = longint'($signed(a[15:0])); eb = longint'($signed(b[15:0])); end
        default: begin ea = longint'($signed(a));       eb = longint'($signed(b));       end
      endcase
    end else begin
      ea = longint'({32'd0, a} & m);
      eb = longint'({32'd0, b} & m);
    end
    p  = ea * eb;
    pu = p;
    lo = 32'(pu & m);
    hi = 32'((pu >> n) & m);
    lim = longint'(m >> 1);
    if (sgn) fl = (p > lim) || (p < -lim - 1);
    else     fl = (pu > m);
  endtask

  // Issue one operation and wait for done; returns negedges counted until done.
  task automatic run_op(input logic [1:0] sz, input logic sgn, input logic [31:0] a,
                        input logic [31:0] b, output int lat);
    @(negedge clk);
    size_i = sz; signed_i = sgn; opa_i = a; opb_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    opa_i = 32'hDEAD_BEEF; opb_i = 32'hCAFE_F00D;
    lat = 1;
    while (!done_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] ehi, elo, hold_hi, hold_lo;
    logic        efl, hold_fl;
    int          n, lat, extra;

    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", "busy in reset", 32'(busy_o), 32'd0);
    check("R10", "done in reset", 32'(done_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "hi after reset", prod_hi_o, 32'd0);
    check("R10", "lo after reset", prod_lo_o, 32'd0);
    check("R10", "flags after reset", {30'd0, cf_o, of_o}, 32'd0);
    check("R10", "busy after reset", 32'(busy_o), 32'd0);

    // R1 R2 R3 R4 R5 R6 R8: vector table
    for (int i = 0; i < NVEC; i++) begin
      model(VEC[i][66:65], VEC[i][64], VEC[i][63:32], VEC[i][31:0], ehi, elo, efl, n);
      run_op(VEC[i][66:65], VEC[i][64], VEC[i][63:32], VEC[i][31:0], lat);
      check("R8", "latency", 32'(lat), 32'(n + 2));
      check(VEC[i][64] ? "R3" : "R2", "hi", prod_hi_o, ehi);
      check(VEC[i][64] ? "R3" : "R2", "lo", prod_lo_o, elo);
      check(VEC[i][64] ? "R6" : "R5", "cf", 32'(cf_o), 32'(efl));
      check(VEC[i][64] ? "R6" : "R5", "of", 32'(of_o), 32'(efl));
      check("R8", "busy low at done", 32'(busy_o), 32'd0);
      if (n < 32) check("R4", "upper bits zero", (prod_hi_o | prod_lo_o) >> n, 32'd0);
      if (VEC[i][66:65] == 2'b11) check("R1", "code 11 acts as 32-bit lo", prod_lo_o, elo);
      @(negedge clk);
      check("R8", "done single cycle", 32'(done_o), 32'd0);
    end

    // R1: garbage above bit 7 ignored (explicit value -128 * 1)
    run_op(2'b00, 1'b1, 32'hABCD_FF80, 32'h1234_5601, lat);
    check("R1", "byte lo", prod_lo_o, 32'h0000_0080);
    check("R1", "byte hi", prod_hi_o, 32'h0000_00FF);

    // R9: hold through idle time
    hold_hi = prod_hi_o; hold_lo = prod_lo_o; hold_fl = cf_o;
    repeat (6) @(negedge clk);
    check("R9", "hi held idle", prod_hi_o, hold_hi);
    check("R9", "lo held idle", prod_lo_o, hold_lo);
    check("R9", "flag held idle", 32'(cf_o), 32'(hold_fl));

    // R7 + R9: start pulse mid-run is ignored; results held during run
    @(negedge clk);
    size_i = 2'b01; signed_i = 1'b0; opa_i = 32'h0000_1234; opb_i = 32'h0000_0100;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    repeat (3) begin @(negedge clk); lat++; end
    check("R9", "hi held during run", prod_hi_o, hold_hi);
    check("R9", "lo held during run", prod_lo_o, hold_lo);
    size_i = 2'b00; signed_i = 1'b1; opa_i = 32'h5; opb_i = 32'h7; start_i = 1'b1;
    @(negedge clk);
    lat++;
    start_i = 1'b0;
    while (!done_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R7", "latency unchanged", 32'(lat), 32'd18);
    check("R7", "lo of first op", prod_lo_o, 32'h0000_3400);
    check("R7", "hi of first op", prod_hi_o, 32'h0000_0012);
    check("R7", "flag of first op", 32'(cf_o), 32'd1);
    extra = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    check("R7", "no second completion", 32'(extra), 32'd0);
    check("R7", "idle after run", 32'(busy_o), 32'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule